// File: doc/BRIEF.md
# Line Brownout and Range Supervisor

This block watches a periodically sampled, already filtered line-voltage level (an unsigned millivolt value) and decides when the power-factor stage and the flyback PWM stage may run. It also decides whether the power-factor output should sit at its high or its reduced level. Time is measured in milliseconds built from an incoming tick strobe, so one parameter sets how many strobes make a millisecond.

A sustained sag of the line puts the converter into brownout. The power-factor stage stops first, and the PWM stage follows after a fixed stagger. Restart needs the line to climb clearly above the trip level. The range select has its own pair of thresholds with hysteresis between them, and it changes only after the line has held past a threshold for a qualification delay. Each delay starts again from zero whenever the line crosses back before the delay has run out.

Top module: `line_supervisor`

## Requirements
- R1: The line counts as low only when the held sample is strictly below UV_TRIP_MV (default 800). `pfc_en` falls after the line has been low for BO_MS (default 195) consecutive milliseconds.
- R2: A held sample at or above UV_TRIP_MV before BO_MS has elapsed clears the brownout delay. The next low period then needs a full BO_MS again.
- R3: `pwm_en` falls STAGGER_MS (default 12) milliseconds after `pfc_en` falls. The line level during that interval does not change this.
- R4: After a brownout, both enables rise together in the same cycle, and only once the held sample is strictly above RECOVER_MV (default 980). A level between the trip and recovery levels keeps both low.
- R5: Reset (asynchronous, active low) forces both enables low, the range select low and the held sample to 0. After reset the enables stay low until a sample strictly above RECOVER_MV is held.
- R6: `range_hi_en` (1 = high output voltage, 0 = reduced) rises after the held sample has been strictly above RANGE_HI_MV (default 1950) for RANGE_MS (default 170) consecutive milliseconds.
- R7: `range_hi_en` falls after the held sample has been strictly below RANGE_LO_MV (default 1600) for RANGE_MS consecutive milliseconds. Between the two thresholds it holds its value.
- R8: A crossing back over the active range threshold before RANGE_MS has elapsed clears the range delay, so the full delay starts again.
- R9: One millisecond is MS_TICKS `tick` strobes. Every delay counts in these milliseconds.
- R10: `sample_mv` is taken into the held sample only in cycles with `sample_valid` high. At other times changes on it have no effect.
- R11: `pfc_en` is never high while `pwm_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick | input | 1 | Time-base strobe; MS_TICKS strobes make one millisecond |
| sample_valid | input | 1 | Qualifies `sample_mv` for one cycle |
| sample_mv | input | MV_W | Filtered line level in millivolts, unsigned |
| pfc_en | output | 1 | Power-factor stage enable |
| pwm_en | output | 1 | Flyback PWM stage enable |
| range_hi_en | output | 1 | 1 selects the high output-voltage level, 0 the reduced level |

## Verification
The bench drives the line to the exact trip, recovery and range levels, where a comparator that is inclusive instead of strict would trip, recover or switch range one step too early. It cuts a low period short one millisecond before expiry and checks that the delay starts again from zero; a design that only paused its counter would shut down early. It raises the line during the stagger and expects the PWM stage to stop anyway. It then gives exactly one strobe less than a full delay, which catches a design that counts strobes instead of milliseconds or has an off-by-one limit. It also changes the sample without its valid strobe, and a design that leaked that value through would shut down.

// File: rtl/line_sup_pkg.sv
package line_sup_pkg;

  typedef enum logic [1:0] {
    ST_OFF      = 2'd0,
    ST_RUN      = 2'd1,
    ST_PFC_DOWN = 2'd2
  } bo_state_e;

endpackage

// File: rtl/ms_prescaler.sv
module ms_prescaler #(
  parameter int MS_TICKS = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  output logic ms_pulse
);

  localparam int PW = (MS_TICKS > 1) ? $clog2(MS_TICKS) : 1;

  generate
    if (MS_TICKS <= 1) begin : g_direct
      assign ms_pulse = tick;
    end else begin : g_divide
      localparam logic [PW-1:0] LAST = PW'(MS_TICKS - 1);
      logic [PW-1:0] pcnt_q, pcnt_d;

      always_comb begin
        pcnt_d = pcnt_q;
        if (tick) begin
          pcnt_d = (pcnt_q == LAST) ? '0 : pcnt_q + 1'b1;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pcnt_q <= '0;
        else        pcnt_q <= pcnt_d;
      end

      assign ms_pulse = tick && (pcnt_q == LAST);

      // R9: divider count stays inside its period
      a_r9_prescale_bound: assert property (@(posedge clk) disable iff (!rst_n)
        pcnt_q <= LAST);
    end
  endgenerate

endmodule

// File: rtl/qual_timer.sv
module qual_timer #(
  parameter int LIMIT = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic step,
  output logic done
);

  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(LIMIT);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    if (!run)                      cnt_d = '0;
    else if (step && cnt_q != LIM) cnt_d = cnt_q + 1'b1;
    else                           cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign done = run && (cnt_q == LIM);

  // R2, R8: a dropped qualifier restarts the delay from zero
  a_r2_restart: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> cnt_q == '0);

  a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LIM);

endmodule

// File: rtl/brownout_fsm.sv
module brownout_fsm
  import line_sup_pkg::*;
#(
  parameter int BO_MS      = 195,
  parameter int STAGGER_MS = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ms_step,
  input  logic line_low,
  input  logic line_recovered,
  output logic pfc_en,
  output logic pwm_en
);

  bo_state_e state_q, state_d;
  logic bo_run, bo_done, stag_run, stag_done;

  assign bo_run   = (state_q == ST_RUN) && line_low;
  assign stag_run = (state_q == ST_PFC_DOWN);

  qual_timer #(.LIMIT(BO_MS)) u_bo_timer (
    .clk(clk), .rst_n(rst_n), .run(bo_run), .step(ms_step), .done(bo_done)
  );

  qual_timer #(.LIMIT(STAGGER_MS)) u_stag_timer (
    .clk(clk), .rst_n(rst_n), .run(stag_run), .step(ms_step), .done(stag_done)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_OFF:      if (line_recovered) state_d = ST_RUN;
      ST_RUN:      if (bo_done)        state_d = ST_PFC_DOWN;
      ST_PFC_DOWN: if (stag_done)      state_d = ST_OFF;
      default:                         state_d = ST_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_OFF;
    else        state_q <= state_d;
  end

  assign pfc_en = (state_q == ST_RUN);
  assign pwm_en = (state_q != ST_OFF);

  // R4: both stages start in the same cycle, and only after recovery was seen
  a_r4_rise_together: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pfc_en) |-> $rose(pwm_en) && $past(line_recovered));

  // R3: PWM stops only after the power-factor stage has already stopped
  a_r3_pwm_after_pfc: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pwm_en) |-> !pfc_en && $past(!pfc_en));

  // R1: power-factor stage stops only while the line is low
  a_r1_trip_when_low: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pfc_en) |-> $past(line_low));

endmodule

// File: rtl/range_ctrl.sv
module range_ctrl #(
  parameter int RANGE_MS = 170
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ms_step,
  input  logic above_hi,
  input  logic below_lo,
  output logic range_hi_en
);

  logic rng_q, rng_d, rng_run, rng_done;

  assign rng_run = rng_q ? below_lo : above_hi;

  qual_timer #(.LIMIT(RANGE_MS)) u_rng_timer (
    .clk(clk), .rst_n(rst_n), .run(rng_run), .step(ms_step), .done(rng_done)
  );

  always_comb begin
    rng_d = rng_q;
    if (rng_done) rng_d = !rng_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rng_q <= 1'b0;
    else        rng_q <= rng_d;
  end

  assign range_hi_en = rng_q;

  // R6: high range only after the line was above the high threshold
  a_r6_rise_cond: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(range_hi_en) |-> $past(above_hi));

  // R7: reduced range only after the line was below the low threshold
  a_r7_fall_cond: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(range_hi_en) |-> $past(below_lo));

endmodule

// File: rtl/line_supervisor.sv
module line_supervisor #(
  parameter int MV_W        = 16,
  parameter int MS_TICKS    = 1,
  parameter int UV_TRIP_MV  = 800,
  parameter int RECOVER_MV  = 980,
  parameter int RANGE_HI_MV = 1950,
  parameter int RANGE_LO_MV = 1600,
  parameter int BO_MS       = 195,
  parameter int STAGGER_MS  = 12,
  parameter int RANGE_MS    = 170
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic            sample_valid,
  input  logic [MV_W-1:0] sample_mv,
  output logic            pfc_en,
  output logic            pwm_en,
  output logic            range_hi_en
);

  localparam logic [MV_W-1:0] TRIP_LVL = MV_W'(UV_TRIP_MV);
  localparam logic [MV_W-1:0] REC_LVL  = MV_W'(RECOVER_MV);
  localparam logic [MV_W-1:0] HI_LVL   = MV_W'(RANGE_HI_MV);
  localparam logic [MV_W-1:0] LO_LVL   = MV_W'(RANGE_LO_MV);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_n_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end

  assign rst_n_int = rst_sync_q[1];

  // held line sample
  logic [MV_W-1:0] level_q, level_d;

  always_comb begin
    level_d = level_q;
    if (sample_valid) level_d = sample_mv;
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) level_q <= '0;
    else            level_q <= level_d;
  end

  logic line_low, line_recovered, above_hi, below_lo, ms_step;

  assign line_low       = level_q < TRIP_LVL;
  assign line_recovered = level_q > REC_LVL;
  assign above_hi       = level_q > HI_LVL;
  assign below_lo       = level_q < LO_LVL;

  ms_prescaler #(.MS_TICKS(MS_TICKS)) u_prescaler (
    .clk(clk), .rst_n(rst_n_int), .tick(tick), .ms_pulse(ms_step)
  );

  brownout_fsm #(.BO_MS(BO_MS), .STAGGER_MS(STAGGER_MS)) u_brownout (
    .clk(clk), .rst_n(rst_n_int), .ms_step(ms_step),
    .line_low(line_low), .line_recovered(line_recovered),
    .pfc_en(pfc_en), .pwm_en(pwm_en)
  );

  range_ctrl #(.RANGE_MS(RANGE_MS)) u_range (
    .clk(clk), .rst_n(rst_n_int), .ms_step(ms_step),
    .above_hi(above_hi), .below_lo(below_lo), .range_hi_en(range_hi_en)
  );

  // R11: the power-factor stage never runs without the PWM stage
  a_r11_stage_order: assert property (@(posedge clk) disable iff (!rst_n_int)
    pfc_en |-> pwm_en);

  // R10: the held sample moves only on a valid strobe
  a_r10_hold_sample: assert property (@(posedge clk) disable iff (!rst_n_int)
    !$past(sample_valid) |-> $stable(level_q));

endmodule

// File: tb/line_supervisor_test.sv
module line_supervisor_test;

  localparam int MS_TICKS = 2;
  localparam int BO_MS    = 5;
  localparam int STAG_MS  = 3;
  localparam int RNG_MS   = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        sample_valid = 1'b0;
  logic [15:0] sample_mv = '0;
  logic        pfc_en, pwm_en, range_hi_en;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  line_supervisor #(
    .MV_W(16), .MS_TICKS(MS_TICKS), .UV_TRIP_MV(800), .RECOVER_MV(980),
    .RANGE_HI_MV(1950), .RANGE_LO_MV(1600),
    .BO_MS(BO_MS), .STAGGER_MS(STAG_MS), .RANGE_MS(RNG_MS)
  ) uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .sample_valid(sample_valid),
    .sample_mv(sample_mv), .pfc_en(pfc_en), .pwm_en(pwm_en),
    .range_hi_en(range_hi_en)
  );

  // row: {req[3:0], mv[15:0], ms[7:0], pfc, pwm, range}
  localparam int NV = 29;
  localparam logic [30:0] VEC [NV] = '{
    {4'd4,  16'd900,  8'd2, 3'b000},  // R4 between levels after reset: stay off
    {4'd4,  16'd1000, 8'd1, 3'b110},  // R4 recovery
    {4'd1,  16'd700,  8'd4, 3'b110},  // R1 low but short of delay
    {4'd2,  16'd850,  8'd1, 3'b110},  // R2 excursion back up
    {4'd2,  16'd700,  8'd4, 3'b110},  // R2 delay restarted
    {4'd1,  16'd700,  8'd1, 3'b010},  // R1 brownout, pfc off first
    {4'd3,  16'd700,  8'd2, 3'b010},  // R3 stagger running
    {4'd3,  16'd700,  8'd1, 3'b000},  // R3 pwm off
    {4'd4,  16'd950,  8'd3, 3'b000},  // R4 hysteresis band
    {4'd4,  16'd990,  8'd0, 3'b110},  // R4 above recovery
    {4'd6,  16'd2000, 8'd3, 3'b110},  // R6 short of range delay
    {4'd8,  16'd1800, 8'd1, 3'b110},  // R8 range excursion
    {4'd8,  16'd2000, 8'd4, 3'b111},  // R8 full delay after restart
    {4'd7,  16'd1700, 8'd5, 3'b111},  // R7 range hysteresis
    {4'd7,  16'd1500, 8'd3, 3'b111},  // R7 short of delay
    {4'd7,  16'd1500, 8'd1, 3'b110},  // R7 reduced range
    {4'd1,  16'd700,  8'd5, 3'b010},  // R1 brownout again
    {4'd3,  16'd900,  8'd2, 3'b010},  // R3 line rises during stagger
    {4'd3,  16'd900,  8'd1, 3'b000},  // R3 stagger completes anyway
    {4'd4,  16'd1000, 8'd0, 3'b110},  // R4
    {4'd1,  16'd800,  8'd6, 3'b110},  // R1 exactly at trip is not low
    {4'd1,  16'd799,  8'd5, 3'b010},  // R1 one below trip
    {4'd3,  16'd799,  8'd3, 3'b000},  // R3
    {4'd4,  16'd980,  8'd2, 3'b000},  // R4 exactly at recovery stays off
    {4'd4,  16'd981,  8'd0, 3'b110},  // R4 one above recovery
    {4'd6,  16'd1950, 8'd5, 3'b110},  // R6 exactly at high threshold
    {4'd6,  16'd1951, 8'd4, 3'b111},  // R6 one above
    {4'd7,  16'd1600, 8'd5, 3'b111},  // R7 exactly at low threshold
    {4'd7,  16'd1599, 8'd4, 3'b110}   // R7 one below
  };

  task automatic check(input string tag, input logic [2:0] act, input logic [2:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: {pfc,pwm,range} actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic clocks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_level(input logic [15:0] mv);
    @(negedge clk);
    sample_mv = mv;
    sample_valid = 1'b1;
    @(negedge clk);
    sample_valid = 1'b0;
    clocks(3);
  endtask

  task automatic strobes(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick = 1'b1;
      @(negedge clk) tick = 1'b0;
      clocks(1);
    end
    clocks(4);
  endtask

  function automatic logic [2:0] outs();
    return {pfc_en, pwm_en, range_hi_en};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    clocks(3);
    check("R5 in reset", outs(), 3'b000);
    rst_n = 1'b1;
    clocks(4);
    check("R5 after reset", outs(), 3'b000);

    for (int r = 0; r < NV; r++) begin
      set_level(VEC[r][26:11]);
      strobes(int'(VEC[r][10:3]) * MS_TICKS);
      check($sformatf("R%0d row %0d", VEC[r][30:27], r), outs(), VEC[r][2:0]);
    end

    // R10: sample change without valid is ignored
    set_level(16'd1000);
    @(negedge clk) sample_mv = 16'd500;
    strobes((BO_MS + 1) * MS_TICKS);
    check("R10 no valid", outs(), 3'b110);

    // R9: one strobe short of the brownout delay
    set_level(16'd700);
    strobes(BO_MS * MS_TICKS - 1);
    check("R9 one strobe short", outs(), 3'b110);
    strobes(1);
    check("R9 last strobe", outs(), 3'b010);
    strobes(STAG_MS * MS_TICKS);
    check("R9 stagger", outs(), 3'b000);

    // R5: reset mid-run clears everything
    set_level(16'd2000);
    strobes(RNG_MS * MS_TICKS);
    check("R5 before reset", outs(), 3'b111);
    @(negedge clk) rst_n = 1'b0;
    clocks(1);
    check("R5 async reset", outs(), 3'b000);
    rst_n = 1'b1;
    clocks(3);
    strobes(RNG_MS * MS_TICKS);
    check("R5 held sample cleared", outs(), 3'b000);
    set_level(16'd1000);
    check("R5 restart", outs(), 3'b110);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule